// File: doc/BRIEF.md
# Clock Output Control Register File

This block holds the byte-wide control and status registers of a multi-output clock generator and gates each of its output clocks. A decoded byte-level register port, fed by a serial management slave that sits outside this block, reads and writes five control bytes. The registers hold per-output enables, the source select of the shared 66/48 MHz output, the spread-enable bit (only stored and brought out), the opt-in stop bits of the free-running PCI outputs, and read-only copies of three strap pins. The straps are captured on the first register clock after reset.

The PCI stop mode is entered when the stop pin is low or software clears its run bit. Either source is enough, so hardware and software can each stop the bus clocks. In stop mode the ordinary PCI outputs are held low. A free-running PCI output keeps toggling unless its opt-in bit is set. Every output passes through its own gate cell. The cell brings the enable into the output's own clock domain and changes the gate only while that clock is low. As a result, no output ever shows a shortened high pulse.

Top module: `clkctl_top`

## Requirements
- R1: On the first register clock after reset the block captures the straps. Byte 0 bit 1 then returns strap_fs[0], byte 0 bit 2 returns strap_fs[1], and byte 1 bit 7 returns strap_msel. Later strap pin changes and register writes leave these bits unchanged.
- R2: Reset values: byte 0 = 0x08 plus the strap bits, byte 1 = 0x47 plus the strap bit, byte 2 = 0x7F, byte 3 = 0xC7, byte 4 = 0x3F. Bytes 5 to 7 read 0x00.
- R3: Writes to read-only or reserved bits have no effect. Reserved bits are byte 0 bits 0, 4 and 6, byte 1 bits 3 to 5, byte 2 bit 7, byte 4 bits 6 and 7, and all of bytes 5 to 7. They always read 0.
- R4: Stop mode (stop_active = 1) holds while the stop pin, after a two-flop synchroniser, is low or byte 0 bit 3 is 0. Byte 0 bit 3 reads 1 only when neither condition holds.
- R5: In stop mode every pci_out is held low. A pcif_out whose opt-in bit is 0 keeps toggling.
- R6: Byte 3 bits 3, 4 and 5 set the opt-in for pcif_out[0], [1] and [2] (1 = stops in stop mode, 0 = free running).
- R7: Each output has an enable bit (1 = runs). pci_out[0..6] use byte 2 bits 0..6. cpu_out[0..2] use byte 1 bits 0..2, and cpu_out[3] uses byte 1 bit 6. pcif_out[0..2] use byte 3 bits 0..2. usb_out uses byte 3 bit 6 and dot_out uses byte 3 bit 7. c66_out[0..5] use byte 4 bits 0..5.
- R8: Byte 0 bit 5 selects the source of c66_out[4]: 0 = c66_clk, 1 = c48_clk.
- R9: A gated output changes only while its source clock is low. Every high pulse it gives is a full high phase of its source.
- R10: Byte 0 bit 7 is stored and drives spread_en. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Byte index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| strap_fs | input | 2 | Frequency strap pins |
| strap_msel | input | 1 | Swing strap pin |
| stop_n | input | 1 | Active-low stop pin (asynchronous) |
| pci_clk | input | 1 | Free-running PCI source clock |
| cpu_clk | input | 1 | Free-running CPU source clock |
| c66_clk | input | 1 | Free-running 66 MHz source clock |
| c48_clk | input | 1 | Free-running 48 MHz source clock |
| pci_out | output | 7 | Stoppable PCI clocks |
| pcif_out | output | 3 | Free-running PCI clocks with opt-in stop |
| cpu_out | output | 4 | CPU clocks |
| c66_out | output | 6 | 66 MHz clocks; bit 4 is the shared 66/48 output |
| usb_out | output | 1 | 48 MHz USB clock |
| dot_out | output | 1 | 48 MHz display clock |
| stop_active | output | 1 | Stop mode status |
| spread_en | output | 1 | Spread enable control bit |

## Verification
The assertions check the following on every cycle:
- reserved read bits stay zero;
- the swing strap bit never moves once captured;
- a low pin two cycles back, or a software write of a zero run bit, forces stop mode;
- the edges of the first PCI output coincide with edges of its source.

The bench's reference model compares the readback, stop_active and spread_en on every clock. Only the bench's scenarios can show which outputs actually stop or keep toggling under each mix of pin, run bit, opt-in and enables. The same holds for the source swap of the shared output and for full-width high pulses measured on the other clock groups.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int N_PCI       = 7;
    localparam int N_PCIF      = 3;
    localparam int N_CPU       = 4;
    localparam int N_66        = 6;
    localparam int IDX_VCH     = 4;
    localparam int SYNC_STAGES = 2;
    localparam int AW          = 3;
    localparam int DW          = 8;

    typedef struct packed {
        logic                   init;
        logic [1:0]             fs;
        logic                   msel;
        logic                   sw_run;
        logic                   vch48;
        logic                   spread;
        logic [N_CPU-1:0]       cpu_en;
        logic [N_PCI-1:0]       pci_en;
        logic [N_PCIF-1:0]      pcif_en;
        logic [N_PCIF-1:0]      pcif_stop;
        logic                   usb_en;
        logic                   dot_en;
        logic [N_66-1:0]        c66_en;
        logic [SYNC_STAGES-1:0] pin_sync;
        logic [N_PCI-1:0]       pci_g;
        logic [N_PCIF-1:0]      pcif_g;
        logic [N_CPU-1:0]       cpu_g;
        logic [N_66-1:0]        c66_g;
        logic                   vch_g;
        logic                   usb_g;
        logic                   dot_g;
    } regs_t;
endpackage

// File: rtl/clkctl_gate.sv
module clkctl_gate #(
    parameter int SYNC = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en,
    output logic clk_gated
);
    logic [SYNC-1:0] sync_q;
    logic [SYNC-1:0] sync_d;
    logic            open_q;

    always_comb begin
        sync_d = {sync_q[SYNC-2:0], en};
    end

    // enable crosses into the source domain on rising edges
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // gate moves only on falling edges, so only while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= sync_q[SYNC-1];
    end

    assign clk_gated = clk_src & open_q;
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [1:0]        strap_fs,
    input  logic              strap_msel,
    input  logic              stop_n,
    output logic [N_PCI-1:0]  pci_g,
    output logic [N_PCIF-1:0] pcif_g,
    output logic [N_CPU-1:0]  cpu_g,
    output logic [N_66-1:0]   c66_g,
    output logic              vch_g,
    output logic              usb_g,
    output logic              dot_g,
    output logic              stop_active,
    output logic              spread_en
);
    localparam regs_t REGS_RST = '{
        init: 1'b0, fs: 2'b00, msel: 1'b0, sw_run: 1'b1, vch48: 1'b0, spread: 1'b0,
        cpu_en: '1, pci_en: '1, pcif_en: '1, pcif_stop: '0, usb_en: 1'b1, dot_en: 1'b1,
        c66_en: '1, pin_sync: '1, pci_g: '1, pcif_g: '1, cpu_g: '1, c66_g: '1,
        vch_g: 1'b0, usb_g: 1'b1, dot_g: 1'b1};

    regs_t q, d;
    logic  stop_now;

    assign stop_now = !q.pin_sync[SYNC_STAGES-1] || !q.sw_run;

    always_comb begin
        d = q;
        d.pin_sync = {q.pin_sync[SYNC_STAGES-2:0], stop_n};
        if (!q.init) begin
            d.init = 1'b1;
            d.fs   = strap_fs;
            d.msel = strap_msel;
        end
        if (wr) begin
            case (addr)
                3'd0: begin
                    d.sw_run = wdata[3];
                    d.vch48  = wdata[5];
                    d.spread = wdata[7];
                end
                3'd1: d.cpu_en = {wdata[6], wdata[2:0]};
                3'd2: d.pci_en = wdata[N_PCI-1:0];
                3'd3: begin
                    d.pcif_en   = wdata[2:0];
                    d.pcif_stop = wdata[5:3];
                    d.usb_en    = wdata[6];
                    d.dot_en    = wdata[7];
                end
                3'd4: d.c66_en = wdata[N_66-1:0];
                default: ;
            endcase
        end
        // registered enables: glitch-free inputs for the gate synchronisers
        d.pci_g  = q.pci_en & {N_PCI{!stop_now}};
        d.pcif_g = q.pcif_en & ~(q.pcif_stop & {N_PCIF{stop_now}});
        d.cpu_g  = q.cpu_en;
        d.c66_g  = q.c66_en;
        d.c66_g[IDX_VCH] = q.c66_en[IDX_VCH] & !q.vch48;
        d.vch_g  = q.c66_en[IDX_VCH] & q.vch48;
        d.usb_g  = q.usb_en;
        d.dot_g  = q.dot_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = {q.spread, 1'b0, q.vch48, 1'b0, !stop_now, q.fs[1], q.fs[0], 1'b0};
            3'd1:    rdata = {q.msel, q.cpu_en[3], 3'b000, q.cpu_en[2:0]};
            3'd2:    rdata = {1'b0, q.pci_en};
            3'd3:    rdata = {q.dot_en, q.usb_en, q.pcif_stop, q.pcif_en};
            3'd4:    rdata = {2'b00, q.c66_en};
            default: rdata = '0;
        endcase
    end

    assign pci_g       = q.pci_g;
    assign pcif_g      = q.pcif_g;
    assign cpu_g       = q.cpu_g;
    assign c66_g       = q.c66_g;
    assign vch_g       = q.vch_g;
    assign usb_g       = q.usb_g;
    assign dot_g       = q.dot_g;
    assign stop_active = stop_now;
    assign spread_en   = q.spread;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [1:0]        strap_fs,
    input  logic              strap_msel,
    input  logic              stop_n,
    input  logic              pci_clk,
    input  logic              cpu_clk,
    input  logic              c66_clk,
    input  logic              c48_clk,
    output logic [N_PCI-1:0]  pci_out,
    output logic [N_PCIF-1:0] pcif_out,
    output logic [N_CPU-1:0]  cpu_out,
    output logic [N_66-1:0]   c66_out,
    output logic              usb_out,
    output logic              dot_out,
    output logic              stop_active,
    output logic              spread_en
);
    logic [N_PCI-1:0]  pci_g;
    logic [N_PCIF-1:0] pcif_g;
    logic [N_CPU-1:0]  cpu_g;
    logic [N_66-1:0]   c66_g;
    logic              vch_g, usb_g, dot_g;
    logic [N_66-1:0]   c66_raw;
    logic              vch_alt;

    clkctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .strap_fs(strap_fs), .strap_msel(strap_msel), .stop_n(stop_n),
        .pci_g(pci_g), .pcif_g(pcif_g), .cpu_g(cpu_g), .c66_g(c66_g), .vch_g(vch_g),
        .usb_g(usb_g), .dot_g(dot_g), .stop_active(stop_active), .spread_en(spread_en)
    );

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        clkctl_gate #(.SYNC(SYNC_STAGES)) u_g (
            .clk_src(pci_clk), .rst_n(rst_n), .en(pci_g[i]), .clk_gated(pci_out[i]));
    end
    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
        clkctl_gate #(.SYNC(SYNC_STAGES)) u_g (
            .clk_src(pci_clk), .rst_n(rst_n), .en(pcif_g[i]), .clk_gated(pcif_out[i]));
    end
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        clkctl_gate #(.SYNC(SYNC_STAGES)) u_g (
            .clk_src(cpu_clk), .rst_n(rst_n), .en(cpu_g[i]), .clk_gated(cpu_out[i]));
    end
    for (genvar i = 0; i < N_66; i++) begin : g_66
        clkctl_gate #(.SYNC(SYNC_STAGES)) u_g (
            .clk_src(c66_clk), .rst_n(rst_n), .en(c66_g[i]), .clk_gated(c66_raw[i]));
        if (i == IDX_VCH) begin : g_shared
            assign c66_out[i] = c66_raw[i] | vch_alt;
        end else begin : g_plain
            assign c66_out[i] = c66_raw[i];
        end
    end

    clkctl_gate #(.SYNC(SYNC_STAGES)) u_vch48 (
        .clk_src(c48_clk), .rst_n(rst_n), .en(vch_g), .clk_gated(vch_alt));
    clkctl_gate #(.SYNC(SYNC_STAGES)) u_usb (
        .clk_src(c48_clk), .rst_n(rst_n), .en(usb_g), .clk_gated(usb_out));
    clkctl_gate #(.SYNC(SYNC_STAGES)) u_dot (
        .clk_src(c48_clk), .rst_n(rst_n), .en(dot_g), .clk_gated(dot_out));
endmodule

// File: rtl/clkctl_check.sv
module clkctl_check (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       reg_wr,
    input logic       wr_b3,
    input logic [7:0] reg_rdata,
    input logic       stop_n,
    input logic       stop_active,
    input logic       pci_clk,
    input logic       pci0
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && reg_addr == 3'd1 && $past(reg_addr) == 3'd1) |-> $stable(reg_rdata[7]));

    p_rsvd_b0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> (!reg_rdata[0] && !reg_rdata[4] && !reg_rdata[6]));

    p_rsvd_b2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd2) |-> !reg_rdata[7]);

    p_rsvd_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 3'd4) |-> (reg_rdata == 8'h00));

    p_pin_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !$past(stop_n, 2)) |-> stop_active);

    p_sw_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(reg_wr && reg_addr == 3'd0 && !wr_b3)) |-> stop_active);

    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $rose(pci0)) |-> $rose(pci_clk));

    p_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $fell(pci0)) |-> $fell(pci_clk));
endmodule

bind clkctl_top clkctl_check u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .wr_b3(reg_wdata[3]),
    .reg_rdata(reg_rdata), .stop_n(stop_n), .stop_active(stop_active),
    .pci_clk(pci_clk), .pci0(pci_out[0])
);

// File: tb/sim_clkctl_top.sv
`timescale 1ns/1ps
module sim_clkctl_top;
    logic clk = 0, rst_n = 0, reg_wr = 0, strap_msel = 1, stop_n = 1;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [1:0] strap_fs = 2'b10;
    logic pci_clk = 0, cpu_clk = 0, c66_clk = 0, c48_clk = 0;
    logic [6:0] pci_out; logic [2:0] pcif_out; logic [3:0] cpu_out; logic [5:0] c66_out;
    logic usb_out, dot_out, stop_active, spread_en;

    localparam logic [1:0] S_FS = 2'b10;
    localparam logic       S_MS = 1'b1;

    int tests = 0, fails = 0;
    bit cmp_en = 0, skip_pin = 0;

    // reference model state
    logic m_sw = 1, m_vch = 0, m_spr = 0, m_usb = 1, m_dot = 1, m_pin = 1;
    logic [3:0] m_cpu = 4'hF; logic [6:0] m_pci = 7'h7F;
    logic [2:0] m_fen = 3'h7, m_fst = 3'h0; logic [5:0] m_c66 = 6'h3F;

    clkctl_top u0 (.*);

    always #2.5 clk = ~clk;
    always #15  pci_clk = ~pci_clk;
    always #4   cpu_clk = ~cpu_clk;
    always #8   c66_clk = ~c66_clk;
    always #10  c48_clk = ~c48_clk;

    function automatic logic [7:0] mrd(input logic [2:0] a);
        case (a)
            3'd0: mrd = {m_spr, 1'b0, m_vch, 1'b0, m_pin & m_sw, S_FS[1], S_FS[0], 1'b0};
            3'd1: mrd = {S_MS, m_cpu[3], 3'b000, m_cpu[2:0]};
            3'd2: mrd = {1'b0, m_pci};
            3'd3: mrd = {m_dot, m_usb, m_fst, m_fen};
            3'd4: mrd = {2'b00, m_c66};
            default: mrd = 8'h00;
        endcase
    endfunction

    task automatic mwr(input logic [2:0] a, input logic [7:0] v);
        case (a)
            3'd0: begin m_sw = v[3]; m_vch = v[5]; m_spr = v[7]; end
            3'd1: m_cpu = {v[6], v[2:0]};
            3'd2: m_pci = v[6:0];
            3'd3: begin m_fen = v[2:0]; m_fst = v[5:3]; m_usb = v[6]; m_dot = v[7]; end
            3'd4: m_c66 = v[5:0];
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_pos(input string tag, input int got);
        tests++;
        if (got <= 0) begin
            fails++;
            $display("FAIL %s got=%0d exp=>0", tag, got);
        end
    endtask

    // R2 model compared on every clock (readback, stop status, spread)
    always @(negedge clk) if (cmp_en) begin
        logic [7:0] mask, e;
        mask = (skip_pin && reg_addr == 3'd0) ? 8'hF7 : 8'hFF;
        e = mrd(reg_addr);
        tests++;
        if ((reg_rdata & mask) != (e & mask) || spread_en != m_spr ||
            (!skip_pin && stop_active != !(m_pin & m_sw))) begin
            fails++;
            $display("FAIL R2 model addr=%0d got=%h/%b/%b exp=%h/%b/%b", reg_addr,
                     reg_rdata, spread_en, stop_active, e, m_spr, !(m_pin & m_sw));
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(posedge clk); #1 reg_addr = a; reg_wdata = v; reg_wr = 1;
        @(posedge clk); mwr(a, v);
        #1 reg_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] e);
        @(posedge clk); #1 reg_addr = a;
        @(negedge clk); chk(tag, reg_rdata, e);
    endtask

    task automatic set_pin(input logic v);
        @(posedge clk); #1 stop_n = v; skip_pin = 1;
        repeat (3) @(posedge clk);
        m_pin = v;
        #1 skip_pin = 0;
    endtask

    // edge counters and pulse-width monitors
    int n_pci0 = 0, n_pci1 = 0, n_f0 = 0, n_f1 = 0, n_cpu0 = 0, n_cpu3 = 0;
    int n_usb = 0, n_dot = 0, n_vch = 0, n_pw = 0;
    always @(posedge pci_out[0])  n_pci0++;
    always @(posedge pci_out[1])  n_pci1++;
    always @(posedge pcif_out[0]) n_f0++;
    always @(posedge pcif_out[1]) n_f1++;
    always @(posedge cpu_out[0])  n_cpu0++;
    always @(posedge cpu_out[3])  n_cpu3++;
    always @(posedge usb_out)     n_usb++;
    always @(posedge dot_out)     n_dot++;
    always @(posedge c66_out[4])  n_vch++;

    realtime t_p = -1, t_f = -1, t_c = -1, t_v = -1, w_vch = 0;
    task automatic pw(input string tag, input realtime w, input realtime e);
        tests++; n_pw++;
        if (w < e - 0.01 || w > e + 0.01) begin
            fails++;
            $display("FAIL %s pulse got=%0t exp=%0t", tag, w, e);
        end
    endtask
    always @(posedge pci_out[0])  t_p = $realtime;
    always @(negedge pci_out[0])  if (rst_n && t_p >= 0) pw("R9 pci0", $realtime - t_p, 15.0);
    always @(posedge pcif_out[0]) t_f = $realtime;
    always @(negedge pcif_out[0]) if (rst_n && t_f >= 0) pw("R9 pcif0", $realtime - t_f, 15.0);
    always @(posedge cpu_out[0])  t_c = $realtime;
    always @(negedge cpu_out[0])  if (rst_n && t_c >= 0) pw("R9 cpu0", $realtime - t_c, 4.0);
    always @(posedge c66_out[4])  t_v = $realtime;
    always @(negedge c66_out[4])  if (t_v >= 0) w_vch = $realtime - t_v;

    int s_pci0, s_pci1, s_f0, s_f1, s_cpu0, s_cpu3, s_usb, s_dot, s_vch;
    task automatic settle_win();
        #300;
        s_pci0 = n_pci0; s_pci1 = n_pci1; s_f0 = n_f0; s_f1 = n_f1; s_cpu0 = n_cpu0;
        s_cpu3 = n_cpu3; s_usb = n_usb; s_dot = n_dot; s_vch = n_vch;
        #300;
        s_pci0 = n_pci0 - s_pci0; s_pci1 = n_pci1 - s_pci1; s_f0 = n_f0 - s_f0;
        s_f1 = n_f1 - s_f1; s_cpu0 = n_cpu0 - s_cpu0; s_cpu3 = n_cpu3 - s_cpu3;
        s_usb = n_usb - s_usb; s_dot = n_dot - s_dot; s_vch = n_vch - s_vch;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (10) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1 cmp_en = 1;

        // R2 reset values
        rd_chk("R2 byte0", 3'd0, 8'h0C);
        rd_chk("R2 byte1", 3'd1, 8'hC7);
        rd_chk("R2 byte2", 3'd2, 8'h7F);
        rd_chk("R2 byte3", 3'd3, 8'hC7);
        rd_chk("R2 byte4", 3'd4, 8'h3F);
        rd_chk("R2 byte6", 3'd6, 8'h00);
        chk("R10 spread reset", spread_en, 0);
        settle_win();
        chk_pos("R7 pci0 runs", s_pci0);
        chk_pos("R7 cpu0 runs", s_cpu0);
        chk_pos("R7 dot runs", s_dot);
        chk("R8 shared from 66 (x10)", int'(w_vch * 10), 80);

        // R1 straps frozen
        strap_fs = 2'b01; strap_msel = 0;
        wr_reg(3'd1, 8'h00);
        rd_chk("R1 msel kept", 3'd1, 8'h80);
        rd_chk("R1 fs kept", 3'd0, 8'h0C);
        wr_reg(3'd1, 8'h47);

        // R3 / R10 read-only and reserved bits
        wr_reg(3'd0, 8'hFF);
        rd_chk("R3 byte0", 3'd0, 8'hAC);
        chk("R10 spread set", spread_en, 1);
        wr_reg(3'd2, 8'hFF); rd_chk("R3 byte2", 3'd2, 8'h7F);
        wr_reg(3'd4, 8'hFF); rd_chk("R3 byte4", 3'd4, 8'h3F);
        wr_reg(3'd5, 8'hFF); rd_chk("R3 byte5", 3'd5, 8'h00);
        rd_chk("R3 byte2 after byte5 write", 3'd2, 8'h7F);
        wr_reg(3'd0, 8'h08);
        chk("R10 spread clear", spread_en, 0);

        // R5 hardware stop
        set_pin(0);
        chk("R4 pin stop", stop_active, 1);
        rd_chk("R4 run bit reads 0", 3'd0, 8'h04);
        settle_win();
        chk("R5 pci0 held", s_pci0, 0);
        chk("R5 pci all low", pci_out, 0);
        chk_pos("R5 pcif0 free", s_f0);

        // R6 opt-in stop for pcif0
        wr_reg(3'd3, 8'hCF);
        settle_win();
        chk("R6 pcif0 stopped", s_f0, 0);
        chk_pos("R6 pcif1 free", s_f1);
        set_pin(1);
        chk("R4 pin released", stop_active, 0);
        settle_win();
        chk_pos("R5 pci0 resumes", s_pci0);
        chk_pos("R6 pcif0 resumes", s_f0);
        wr_reg(3'd3, 8'hC7);

        // R4 software stop
        wr_reg(3'd0, 8'h00);
        chk("R4 sw stop", stop_active, 1);
        settle_win();
        chk("R4 pci0 held by sw", s_pci0, 0);
        wr_reg(3'd0, 8'h08);
        chk("R4 sw release", stop_active, 0);
        settle_win();
        chk_pos("R4 pci0 after sw", s_pci0);

        // R7 enables
        wr_reg(3'd2, 8'h7E); wr_reg(3'd1, 8'h07); wr_reg(3'd3, 8'h47); wr_reg(3'd4, 8'h2F);
        settle_win();
        chk("R7 pci0 off", s_pci0, 0);
        chk_pos("R7 pci1 on", s_pci1);
        chk("R7 cpu3 off", s_cpu3, 0);
        chk_pos("R7 cpu0 on", s_cpu0);
        chk("R7 dot off", s_dot, 0);
        chk_pos("R7 usb on", s_usb);
        chk("R7 shared off", s_vch, 0);
        wr_reg(3'd2, 8'h7F); wr_reg(3'd1, 8'h47); wr_reg(3'd3, 8'hC7); wr_reg(3'd4, 8'h3F);

        // R8 shared output from 48 MHz
        wr_reg(3'd0, 8'h28);
        settle_win();
        chk_pos("R8 shared runs", s_vch);
        chk("R8 shared from 48 (x10)", int'(w_vch * 10), 100);
        wr_reg(3'd0, 8'h08);
        settle_win();
        chk("R8 shared back to 66 (x10)", int'(w_vch * 10), 80);
        chk_pos("R9 pulses measured", n_pw);

        cmp_en = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule